// File: doc/BRIEF.md
# Return-Address Stack with Fill-Level Warning

This block is a last-in, first-out store for program-counter values saved on subroutine calls and interrupt entry. A push writes a word onto the top and a pop discards the top. The current top word is always visible on an output, so the sequencer reads the return address directly. The block reports its fill count, empty and full flags, and two sticky error flags for pushes that find no room and pops that find nothing to remove.

A warning request tells software that the stack is close to running dry or close to overflowing. The request is asserted while the occupancy is below a low mark or above a high mark, and only while its enable input is high. The default build holds 33 entries, with marks at 3 and 28. That depth is not a power of two, so all full and index logic compares against the exact depth. The same block is built at depth 8 for loop nesting and at depth 16 for saved status. The enable input is driven from a control-register bit: bit 10 for the program-counter stack and bit 11 for the loop stack.

Top module: `hw_call_stack`

## Requirements
- R1: A push without a pop, while count is below DEPTH, stores the push data as the new top and raises count by one in the next cycle.
- R2: A pop without a push, while count is nonzero, lowers count by one, and the top output then shows the word pushed before the removed one.
- R3: A push without a pop while count equals DEPTH leaves count and top unchanged and sets overflow_o, which stays set until reset.
- R4: A pop without a push while count is zero leaves count at zero, top_o reads zero, and underflow_o is set and stays set until reset.
- R5: A push and a pop in the same cycle on a non-empty stack replace the top word with the push data and leave count unchanged. This also holds when the stack is full, and it does not set overflow_o.
- R6: A push and a pop in the same cycle on an empty stack set underflow_o and store the push data as the single entry, so count becomes 1.
- R7: empty_o is high exactly when count is zero, and full_o is high exactly when count equals DEPTH. top_o reads zero whenever the stack is empty.
- R8: With lvl_irq_en_i high, lvl_irq_o is high exactly when count is below LOW_MARK (default 3) or above HIGH_MARK (default 28). It is a level that follows count in the same cycle, not a latched pulse.
- R9: With lvl_irq_en_i low, lvl_irq_o is low at every count.
- R10: While rst_ni is low, count is zero and both error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | WIDTH | Word to push |
| lvl_irq_en_i | input | 1 | Enable for the fill-level request |
| top_o | output | WIDTH | Current top word, zero when empty |
| count_o | output | $clog2(DEPTH+1) | Number of entries held |
| empty_o | output | 1 | Count is zero |
| full_o | output | 1 | Count equals DEPTH |
| overflow_o | output | 1 | Sticky: a push was refused |
| underflow_o | output | 1 | Sticky: a pop found the stack empty |
| lvl_irq_o | output | 1 | Fill-level warning request |

## Verification
The hardest cases are those at the full boundary: a refused push and a same-cycle replace while all 33 entries are held. Reaching them from the ports takes 33 back-to-back pushes. The stimulus first fills the stack one entry at a time, checking every count from 0 to 33 against both marks. It then issues the refused push and the replace while full, and drains the stack, checking each returned word. After that, a long pseudo-random run of push, pop and combined operations, biased toward pushing, repeatedly crosses both marks and both ends, with the enable toggled along the way.

// File: rtl/hw_stack_pkg.sv
package hw_stack_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_SWAP = 2'd3
  } stk_op_e;
endpackage

// File: rtl/hw_stack_ctrl.sv
module hw_stack_ctrl
  import hw_stack_pkg::*;
#(
  parameter int DEPTH = 33,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [CW-1:0] count_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_idx_o,
  output logic [AW-1:0] top_idx_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, unf_q, unf_d;
  logic          is_empty, is_full;
  stk_op_e       op;

  assign is_empty  = (cnt_q == '0);
  assign is_full   = (cnt_q == FULL_CNT);
  assign top_idx_o = AW'(cnt_q - CW'(1));

  // decode the effective operation
  always_comb begin
    op = STK_IDLE;
    if (push_i && pop_i)          op = is_empty ? STK_PUSH : STK_SWAP;
    else if (push_i && !is_full)  op = STK_PUSH;
    else if (pop_i && !is_empty)  op = STK_POP;
  end

  always_comb begin
    cnt_d    = cnt_q;
    ovf_d    = ovf_q;
    unf_d    = unf_q;
    wr_en_o  = 1'b0;
    wr_idx_o = AW'(cnt_q);
    unique case (op)
      STK_PUSH: begin
        cnt_d   = cnt_q + CW'(1);
        wr_en_o = 1'b1;
      end
      STK_POP:  cnt_d = cnt_q - CW'(1);
      STK_SWAP: begin
        wr_en_o  = 1'b1;
        wr_idx_o = top_idx_o;
      end
      default: ;
    endcase
    if (push_i && !pop_i && is_full) ovf_d = 1'b1;
    if (pop_i && is_empty)           unf_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r4_unf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |=> unf_q);
endmodule

// File: rtl/hw_stack_store.sv
module hw_stack_store #(
  parameter int DEPTH = 33,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             empty_i,
  input  logic [AW-1:0]    top_idx_i,
  output logic [WIDTH-1:0] top_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  // one enabled register per entry, no reset needed for data storage
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == AW'(g));
    always_ff @(posedge clk_i) begin
      if (sel) slot_q[g] <= wr_data_i;
    end
  end

  assign top_o = empty_i ? '0 : slot_q[top_idx_i];
endmodule

// File: rtl/hw_stack_level.sv
module hw_stack_level #(
  parameter int DEPTH     = 33,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 28,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count_i,
  input  logic          en_i,
  output logic          irq_o
);
  logic below, above;
  assign below = (count_i < CW'(LOW_MARK));
  assign above = (count_i > CW'(HIGH_MARK));
  assign irq_o = en_i && (below || above);
endmodule

// File: rtl/hw_call_stack.sv
module hw_call_stack #(
  parameter int DEPTH     = 33,
  parameter int WIDTH     = 16,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 28,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             lvl_irq_en_i,
  output logic [WIDTH-1:0] top_o,
  output logic [CW-1:0]    count_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             overflow_o,
  output logic             underflow_o,
  output logic             lvl_irq_o
);
  logic          wr_en;
  logic [AW-1:0] wr_idx, top_idx;

  hw_stack_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk_i, .rst_ni, .push_i, .pop_i,
    .count_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .top_idx_o(top_idx),
    .ovf_o(overflow_o), .unf_o(underflow_o)
  );

  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == CW'(DEPTH));

  hw_stack_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
    .clk_i, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(push_data_i),
    .empty_i(empty_o), .top_idx_i(top_idx), .top_o
  );

  hw_stack_level #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) level_i (
    .count_i(count_o), .en_i(lvl_irq_en_i), .irq_o(lvl_irq_o)
  );

  a_r1_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o) |=> (count_o == $past(count_o) + CW'(1)) && (top_o == $past(push_data_i)));
  a_r2_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> (count_o == $past(count_o) - CW'(1)));
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> $stable(count_o) && $stable(top_o) && overflow_o);
  a_r4_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> empty_o && underflow_o && (top_o == '0));
  a_r5_replace_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o) |=> $stable(count_o) && (top_o == $past(push_data_i)));
  a_r6_both_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && empty_o) |=> (count_o == CW'(1)) && underflow_o);
  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_irq_en_i |-> !lvl_irq_o);
  a_r8_irq_at_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_irq_en_i && empty_o) |-> lvl_irq_o);
endmodule

// File: tb/hw_call_stack_tb.sv
module hw_call_stack_tb_top;
  localparam int D  = 33;
  localparam int W  = 16;
  localparam int LO = 3;
  localparam int HI = 28;

  logic clk = 1'b0;
  logic rst_n;
  logic push, pop, en;
  logic [W-1:0] din;
  logic [W-1:0] top;
  logic [5:0] cnt;
  logic empty, full, ovf, unf, irq;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  hw_call_stack #(.DEPTH(D), .WIDTH(W), .LOW_MARK(LO), .HIGH_MARK(HI)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .pop_i(pop), .push_data_i(din),
    .lvl_irq_en_i(en), .top_o(top), .count_o(cnt), .empty_o(empty), .full_o(full),
    .overflow_o(ovf), .underflow_o(unf), .lvl_irq_o(irq)
  );

  // reference model
  logic [W-1:0] m_stk [D];
  int m_cnt;
  bit m_ovf, m_unf;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    int exp_top;
    bit exp_irq;
    exp_top = (m_cnt > 0) ? int'(m_stk[m_cnt-1]) : 0;
    exp_irq = en && ((m_cnt < LO) || (m_cnt > HI));
    chk({tag, " count"}, int'(cnt), m_cnt);
    chk({tag, " top"}, int'(top), exp_top);
    chk("R7 empty", int'(empty), int'(m_cnt == 0));
    chk("R7 full", int'(full), int'(m_cnt == D));
    chk("R3 overflow", int'(ovf), int'(m_ovf));
    chk("R4 underflow", int'(unf), int'(m_unf));
    chk(en ? "R8 irq" : "R9 irq", int'(irq), int'(exp_irq));
  endtask

  task automatic op(input bit p, input bit q, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    push = p; pop = q; din = d;
    @(posedge clk);
    #1;
    if (p && q) begin
      if (m_cnt > 0) m_stk[m_cnt-1] = d;
      else begin m_unf = 1'b1; m_stk[0] = d; m_cnt = 1; end
    end else if (p) begin
      if (m_cnt < D) begin m_stk[m_cnt] = d; m_cnt++; end
      else m_ovf = 1'b1;
    end else if (q) begin
      if (m_cnt > 0) m_cnt--;
      else m_unf = 1'b1;
    end
    push = 1'b0; pop = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push = 1'b0; pop = 1'b0;
    m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0;
    #1;
    check_all("R10 reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; push = 1'b0; pop = 1'b0; din = '0; en = 1'b1;
    m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0;
    repeat (3) @(posedge clk);
    do_reset();

    op(1'b0, 1'b1, 16'h1234, "R4 pop empty");
    op(1'b1, 1'b1, 16'h00AA, "R6 both on empty");
    do_reset();

    // fill one at a time: every count against both marks
    for (int k = 0; k < D; k++) op(1'b1, 1'b0, W'(k * 37 + 5), "R1 push");
    op(1'b1, 1'b0, 16'hBEEF, "R3 push full");
    op(1'b1, 1'b1, 16'hC0DE, "R5 swap full");
    en = 1'b0;
    op(1'b0, 1'b0, 16'h0, "R9 idle full");
    en = 1'b1;
    for (int k = 0; k < D; k++) op(1'b0, 1'b1, 16'h0, "R2 pop");
    op(1'b0, 1'b1, 16'h0, "R4 pop empty again");
    do_reset();

    // gate check across a sweep with enable low
    en = 1'b0;
    for (int k = 0; k < D; k++) op(1'b1, 1'b0, W'(k ^ 16'h5A5A), "R9 push");
    op(1'b1, 1'b1, 16'h7777, "R5 swap");
    en = 1'b1;
    for (int k = 0; k < D; k++) op(1'b0, 1'b1, 16'h0, "R2 drain");
    do_reset();

    // pseudo-random mix biased toward pushing
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      bit p, q;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p = (lfsr[2:0] < 3'd5) ^ (k[8]);
      q = lfsr[4] & lfsr[3];
      if (k % 97 == 0) en = ~en;
      op(p, q, lfsr ^ 16'h3C3C, (p && q) ? "R5 mix" : (p ? "R1 mix" : "R2 mix"));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule